// File: doc/BRIEF.md
# Cache Flush and Page Invalidate Sequencer

This block holds the tag, valid and modified state of three small direct-mapped caches: a first-level instruction cache, a first-level data cache and a second-level cache. It runs two kinds of maintenance over them with one walk engine. A global flush starts when the active-low flush input is sampled low. It visits every set of every cache, writes back each modified line of the two data-holding caches, and leaves every line in all three caches invalid. A page operation starts when the page maintenance register is written. It visits only the sets that a line of the named page can occupy, and it invalidates the lines whose address lies in that page. Depending on a control bit, it either writes the modified ones back first or drops them.

Writebacks leave through a valid/ready port as line-aligned addresses tagged with their source cache, and the walk waits on each one until it is accepted. A fill port loads lines into the arrays, and a probe port reports hit and dirty state for an address. A block that needs to put the caches in a known state uses busy and the one-cycle done pulse to follow each operation.

Top module: `mnt_seq`

## Requirements
- R1: When `flush_n` is sampled low while idle, a global flush starts and `busy` is high in the next cycle.
- R2: A global flush presents each modified line of the data cache (`wb_src`=0) and of the second-level cache (`wb_src`=1) exactly once on the writeback port, as a line-aligned address.
- R3: After a global flush, the probe reports a miss for every line that was held in any of the three caches.
- R4: A write on `pmr_wr` while idle starts a page operation, and `busy` is high in the next cycle. Bits `[ADDR_W-1:PAGE_W]` of `pmr_wdata` give the page number. Bit 0 selects the mode: 1 writes back and then invalidates, 0 only invalidates.
- R5: A page operation invalidates exactly the lines whose address bits above `PAGE_W` equal the page number. Every other line keeps its valid and modified state.
- R6: In write-back mode, each modified line of the page in the data cache and in the second-level cache is written back exactly once. The instruction cache never produces a writeback.
- R7: In invalidate-only mode, no writeback is issued, and the modified lines of the page are dropped.
- R8: With the writeback port always ready, `busy` stays high for exactly as many cycles as sets are visited, one set per cycle. A global flush visits every set of every cache. A page operation visits min(2^SETS_W, 2^(PAGE_W-LINE_W)) sets per cache.
- R9: A writeback that is not accepted keeps `wb_valid` high and `wb_addr` unchanged, and the walk does not advance until `wb_ready` is seen.
- R10: After reset, `busy` and `done` are low. `done` is a single-cycle pulse in the cycle after the last set is visited, and `busy` is low in that cycle.
- R11: A flush or register request that arrives while `busy` is high is ignored and does not restart or change the running operation.
- R12: If `flush_n` is low and `pmr_wr` is high in the same idle cycle, the global flush is performed.
- R13: Cache select code 0 is the instruction cache, 1 is the data cache and 2 is the second-level cache. A fill, accepted only while idle, installs a valid line at the index taken from the fill address. The instruction cache never holds a modified line. The probe reports hit and dirty for the line at the probe address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_n | input | 1 | Active-low global flush request |
| pmr_wr | input | 1 | Page maintenance register write strobe |
| pmr_wdata | input | ADDR_W | Page number in the upper bits; bit 0 is the write-back select |
| fill_en | input | 1 | Install a line |
| fill_cache | input | 2 | Target cache of the fill |
| fill_addr | input | ADDR_W | Address of the line to install |
| fill_dirty | input | 1 | Install the line as modified |
| probe_cache | input | 2 | Cache to look up |
| probe_addr | input | ADDR_W | Address to look up |
| probe_hit | output | 1 | The line is present |
| probe_dirty | output | 1 | The line is present and modified |
| wb_valid | output | 1 | Writeback request |
| wb_ready | input | 1 | Writeback accepted |
| wb_addr | output | ADDR_W | Line-aligned writeback address |
| wb_src | output | 1 | 0 = data cache, 1 = second-level cache |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with a 16-bit address, 16-byte lines, 64-byte pages, two-set first-level caches and a 32-set second-level cache. A page then covers four lines. This one build exercises both walk variants: the first-level caches are smaller than a page and are visited in full with a tag compare, while the second-level cache is indexed by page bits. A page operation takes 8 cycles and a global flush takes 36, so both counts are checked exactly. Random fills over sixteen pages cause frequent index conflicts, and random ready stalls exercise the writeback hold.

// File: rtl/mnt_pkg.sv
package mnt_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_L1I  = 2'd1,
      PH_L1D  = 2'd2,
      PH_L2   = 2'd3
   } phase_t;

   localparam int NUM_CACHES = 3;
   localparam logic [1:0] SEL_L1I = 2'd0;
   localparam logic [1:0] SEL_L1D = 2'd1;
   localparam logic [1:0] SEL_L2  = 2'd2;
endpackage

// File: rtl/mnt_tag_array.sv
module mnt_tag_array #(
   parameter int ADDR_W    = 32,
   parameter int LINE_W    = 5,
   parameter int SETS_W    = 8,
   parameter bit CAN_DIRTY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill_en,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic              fill_dirty,
   input  logic [ADDR_W-1:0] probe_addr,
   output logic              probe_hit,
   output logic              probe_dirty,
   input  logic [SETS_W-1:0] walk_idx,
   output logic              walk_valid,
   output logic              walk_dirty,
   output logic [ADDR_W-1:0] walk_line,
   input  logic              clr_en
);
   localparam int SETS  = 1 << SETS_W;
   localparam int TAG_W = ADDR_W - LINE_W - SETS_W;

   initial begin
      assert (TAG_W >= 1 && LINE_W >= 1 && SETS_W >= 1)
         else $error("mnt_tag_array: bad geometry");
   end

   logic [TAG_W-1:0] tag_q [SETS];
   logic [SETS-1:0]  vld_q;
   logic [SETS-1:0]  drt_q;

   logic [SETS_W-1:0] fill_idx;
   logic [SETS_W-1:0] probe_idx;
   logic              fill_d;

   assign fill_idx  = fill_addr[LINE_W +: SETS_W];
   assign probe_idx = probe_addr[LINE_W +: SETS_W];
   assign fill_d    = fill_dirty & CAN_DIRTY;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         drt_q <= '0;
      end else begin
         if (fill_en) begin
            vld_q[fill_idx] <= 1'b1;
            drt_q[fill_idx] <= fill_d;
         end
         if (clr_en) begin
            vld_q[walk_idx] <= 1'b0;
            drt_q[walk_idx] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) tag_q[fill_idx] <= fill_addr[ADDR_W-1 -: TAG_W];
   end

   assign probe_hit   = vld_q[probe_idx] && (tag_q[probe_idx] == probe_addr[ADDR_W-1 -: TAG_W]);
   assign probe_dirty = probe_hit && drt_q[probe_idx];

   assign walk_valid = vld_q[walk_idx];
   assign walk_dirty = drt_q[walk_idx];
   assign walk_line  = {tag_q[walk_idx], walk_idx, {LINE_W{1'b0}}};

   // fills are only accepted while idle, so they never meet a walk clear
   assert_fill_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |-> !fill_en);
endmodule

// File: rtl/mnt_walk_index.sv
module mnt_walk_index #(
   parameter int ADDR_W = 32,
   parameter int LINE_W = 5,
   parameter int PAGE_W = 12,
   parameter int SETS_W = 8
) (
   input  logic [SETS_W-1:0] cnt,
   input  logic              global_mode,
   input  logic [ADDR_W-1:PAGE_W] page_num,
   output logic [SETS_W-1:0] idx,
   output logic              last
);
   localparam int PL_W = PAGE_W - LINE_W;

   initial begin
      assert (PL_W >= 1 && PAGE_W < ADDR_W)
         else $error("mnt_walk_index: page must hold at least two lines");
   end

   generate
      if (SETS_W <= PL_W) begin : g_whole
         // a page can land in every set: visit them all, tag compare decides
         assign idx  = cnt;
         assign last = &cnt;
      end else begin : g_paged
         // upper index bits are fixed by the page number
         assign idx  = global_mode ? cnt
                                   : {page_num[LINE_W+SETS_W-1:PAGE_W], cnt[PL_W-1:0]};
         assign last = global_mode ? (&cnt) : (&cnt[PL_W-1:0]);
      end
   endgenerate
endmodule

// File: rtl/mnt_seq.sv
module mnt_seq
   import mnt_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int LINE_W    = 5,
   parameter int PAGE_W    = 12,
   parameter int L1_SETS_W = 8,
   parameter int L2_SETS_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_n,
   input  logic              pmr_wr,
   input  logic [ADDR_W-1:0] pmr_wdata,
   input  logic              fill_en,
   input  logic [1:0]        fill_cache,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic              fill_dirty,
   input  logic [1:0]        probe_cache,
   input  logic [ADDR_W-1:0] probe_addr,
   output logic              probe_hit,
   output logic              probe_dirty,
   output logic              wb_valid,
   input  logic              wb_ready,
   output logic [ADDR_W-1:0] wb_addr,
   output logic              wb_src,
   output logic              busy,
   output logic              done
);
   localparam int CNT_W = (L1_SETS_W > L2_SETS_W) ? L1_SETS_W : L2_SETS_W;

   initial begin
      assert (PAGE_W > LINE_W && PAGE_W < ADDR_W)
         else $error("mnt_seq: PAGE_W must lie between LINE_W and ADDR_W");
   end

   phase_t                phase_q;
   logic [CNT_W-1:0]      cnt_q;
   logic                  glob_q;
   logic                  wbm_q;
   logic [ADDR_W-1:PAGE_W] pnum_q;
   logic                  done_q;

   logic [NUM_CACHES-1:0][ADDR_W-1:0] w_line;
   logic [NUM_CACHES-1:0] w_vld, w_drt, w_last, w_clr, w_fill, p_hit, p_drt;

   logic              start_glob, start_page, step;
   logic              cur_vld, cur_drt, cur_last, cur_hit, need_wb;
   logic [ADDR_W-1:0] cur_line;
   logic [1:0]        cur_sel;

   assign busy       = (phase_q != PH_IDLE);
   assign start_glob = !busy && !flush_n;
   assign start_page = !busy && flush_n && pmr_wr;

   generate
      for (genvar g = 0; g < NUM_CACHES; g++) begin : g_cache
         localparam int SW = (g == 2) ? L2_SETS_W : L1_SETS_W;
         logic [SW-1:0] idx_g;

         mnt_walk_index #(
            .ADDR_W(ADDR_W), .LINE_W(LINE_W), .PAGE_W(PAGE_W), .SETS_W(SW)
         ) u_idx (
            .cnt        (cnt_q[SW-1:0]),
            .global_mode(glob_q),
            .page_num   (pnum_q),
            .idx        (idx_g),
            .last       (w_last[g])
         );

         assign w_fill[g] = fill_en && !busy && (fill_cache == 2'(g));
         assign w_clr[g]  = step && cur_hit && (cur_sel == 2'(g));

         mnt_tag_array #(
            .ADDR_W(ADDR_W), .LINE_W(LINE_W), .SETS_W(SW), .CAN_DIRTY(g != 0)
         ) u_arr (
            .clk        (clk),
            .rst_n      (rst_n),
            .fill_en    (w_fill[g]),
            .fill_addr  (fill_addr),
            .fill_dirty (fill_dirty),
            .probe_addr (probe_addr),
            .probe_hit  (p_hit[g]),
            .probe_dirty(p_drt[g]),
            .walk_idx   (idx_g),
            .walk_valid (w_vld[g]),
            .walk_dirty (w_drt[g]),
            .walk_line  (w_line[g]),
            .clr_en     (w_clr[g])
         );
      end
   endgenerate

   always_comb begin
      case (phase_q)
         PH_L1D:  cur_sel = SEL_L1D;
         PH_L2:   cur_sel = SEL_L2;
         default: cur_sel = SEL_L1I;
      endcase
   end

   always_comb begin
      case (cur_sel)
         SEL_L1D: begin cur_line = w_line[1]; cur_vld = w_vld[1]; cur_drt = w_drt[1]; cur_last = w_last[1]; end
         SEL_L2:  begin cur_line = w_line[2]; cur_vld = w_vld[2]; cur_drt = w_drt[2]; cur_last = w_last[2]; end
         default: begin cur_line = w_line[0]; cur_vld = w_vld[0]; cur_drt = w_drt[0]; cur_last = w_last[0]; end
      endcase
   end

   always_comb begin
      case (probe_cache)
         SEL_L1I: begin probe_hit = p_hit[0]; probe_dirty = p_drt[0]; end
         SEL_L1D: begin probe_hit = p_hit[1]; probe_dirty = p_drt[1]; end
         SEL_L2:  begin probe_hit = p_hit[2]; probe_dirty = p_drt[2]; end
         default: begin probe_hit = 1'b0;     probe_dirty = 1'b0;     end
      endcase
   end

   assign cur_hit  = busy && cur_vld && (glob_q || (cur_line[ADDR_W-1:PAGE_W] == pnum_q));
   assign need_wb  = cur_hit && cur_drt && wbm_q;
   assign step     = busy && (!need_wb || wb_ready);
   assign wb_valid = need_wb;
   assign wb_addr  = cur_line;
   assign wb_src   = (phase_q == PH_L2);
   assign done     = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         glob_q  <= 1'b0;
         wbm_q   <= 1'b0;
         pnum_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start_glob) begin
            phase_q <= PH_L1I;
            cnt_q   <= '0;
            glob_q  <= 1'b1;
            wbm_q   <= 1'b1;
         end else if (start_page) begin
            phase_q <= PH_L1I;
            cnt_q   <= '0;
            glob_q  <= 1'b0;
            wbm_q   <= pmr_wdata[0];
            pnum_q  <= pmr_wdata[ADDR_W-1:PAGE_W];
         end else if (step) begin
            if (cur_last) begin
               cnt_q <= '0;
               case (phase_q)
                  PH_L1I:  phase_q <= PH_L1D;
                  PH_L1D:  phase_q <= PH_L2;
                  default: begin
                     phase_q <= PH_IDLE;
                     done_q  <= 1'b1;
                  end
               endcase
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assert_flush_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !flush_n) |=> (busy && glob_q));
   assert_page_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && flush_n && pmr_wr) |=> (busy && !glob_q));
   assert_collide_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !flush_n && pmr_wr) |=> glob_q);
   assert_wb_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(cnt_q)));
   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   assert_icache_nowb_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_L1I) |-> !wb_valid);
   assert_inval_nowb_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !wbm_q) |-> !wb_valid);
   assert_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (pmr_wr || !flush_n)) |=> ($stable(pnum_q) && $stable(glob_q) && $stable(wbm_q)));
endmodule

// File: tb/tb_mnt_seq.sv
`timescale 1ns/1ps
module tb_mnt_seq;
   localparam int AW = 16, LW = 4, PW = 6, S1 = 1, S2 = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic flush_n = 1'b1, pmr_wr = 1'b0, fill_en = 1'b0, fill_dirty = 1'b0, wb_ready = 1'b1;
   logic [AW-1:0] pmr_wdata = '0, fill_addr = '0, probe_addr = '0;
   logic [1:0] fill_cache = '0, probe_cache = '0;
   logic probe_hit, probe_dirty, wb_valid, wb_src, busy, done;
   logic [AW-1:0] wb_addr;

   always #10 clk = ~clk;

   mnt_seq #(.ADDR_W(AW), .LINE_W(LW), .PAGE_W(PW), .L1_SETS_W(S1), .L2_SETS_W(S2)) dut (
      .clk(clk), .rst_n(rst_n), .flush_n(flush_n), .pmr_wr(pmr_wr), .pmr_wdata(pmr_wdata),
      .fill_en(fill_en), .fill_cache(fill_cache), .fill_addr(fill_addr), .fill_dirty(fill_dirty),
      .probe_cache(probe_cache), .probe_addr(probe_addr), .probe_hit(probe_hit),
      .probe_dirty(probe_dirty), .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
      .wb_src(wb_src), .busy(busy), .done(done));

   int nchk = 0, nerr = 0;
   bit rv[3][32], rd[3][32], seen[3][32], pend[3][32];
   int la[3][32];
   bit stall = 0, in_op = 0, dseen = 0, hold_prev = 0;
   logic [AW-1:0] hold_addr;
   int bcyc, wbn;
   string cur_req = "R2";

   function automatic int sw(input int c); return (c == 2) ? S2 : S1; endfunction
   function automatic int idx_of(input int addr, input int c);
      return (addr >> LW) & ((1 << sw(c)) - 1);
   endfunction
   function automatic bit in_pg(input int line, input int pn);
      return (line >> (PW - LW)) == pn;
   endfunction

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   // writeback monitor and ready driver
   always @(negedge clk) begin
      wb_ready = stall ? 1'($urandom % 2) : 1'b1;
      #1;
      if (hold_prev) chk(wb_valid && wb_addr == hold_addr, "R9", int'(wb_addr), int'(hold_addr));
      hold_prev = wb_valid && !wb_ready;
      hold_addr = wb_addr;
      if (in_op) begin
         if (busy) bcyc++;
         if (wb_valid && wb_ready) begin
            automatic int c = wb_src ? 2 : 1;
            automatic int i = idx_of(int'(wb_addr), c);
            chk(pend[c][i] && la[c][i] == int'(wb_addr >> LW) && wb_addr[LW-1:0] == '0,
                cur_req, int'(wb_addr), la[c][i] << LW);
            pend[c][i] = 0;
            wbn++;
         end
         if (done) dseen = 1;
      end
   end

   task automatic fill(input int c, input int addr, input bit d);
      int i;
      @(negedge clk); #3;
      fill_en = 1; fill_cache = 2'(c); fill_addr = AW'(addr); fill_dirty = d;
      @(negedge clk); #3;
      fill_en = 0;
      i = idx_of(addr, c);
      rv[c][i] = 1; rd[c][i] = (c != 0) && d; la[c][i] = addr >> LW; seen[c][i] = 1;
   endtask

   task automatic check_all(input string rq);
      for (int c = 0; c < 3; c++)
         for (int i = 0; i < (1 << sw(c)); i++)
            if (seen[c][i]) begin
               probe_cache = 2'(c); probe_addr = AW'(la[c][i] << LW);
               #1;
               chk(probe_hit == rv[c][i] && probe_dirty == (rv[c][i] && rd[c][i]), rq,
                   {probe_hit, probe_dirty}, {rv[c][i], rv[c][i] && rd[c][i]});
            end
   endtask

   // kind: 0 global, 1 page write-back, 2 page invalidate-only, 3 both requests at once
   task automatic run_op(input int kind, input int pn, input bit intr, input bit stl);
      bit glob, wbm;
      int expw;
      string prq;
      glob = (kind == 0 || kind == 3);
      wbm  = glob || kind == 1;
      cur_req = glob ? "R2" : (wbm ? "R6" : "R7");
      prq = (kind == 3) ? "R12" : (glob ? "R3" : "R5");
      expw = 0;
      for (int c = 0; c < 3; c++)
         for (int i = 0; i < 32; i++) begin
            pend[c][i] = (c != 0) && rv[c][i] && rd[c][i] && wbm && (glob || in_pg(la[c][i], pn));
            if (pend[c][i]) expw++;
         end
      @(negedge clk); #3;
      stall = stl; bcyc = 0; wbn = 0; dseen = 0; in_op = 1;
      if (glob) flush_n = 0;
      if (kind != 0) begin pmr_wr = 1; pmr_wdata = AW'((pn << PW) | (kind == 1)); end
      @(negedge clk); #3;
      flush_n = 1; pmr_wr = 0;
      chk(busy, glob ? "R1" : "R4", busy, 1);
      if (intr) begin
         @(negedge clk); #3;
         flush_n = 0; pmr_wr = 1; pmr_wdata = AW'(1);
         @(negedge clk); #3;
         flush_n = 1; pmr_wr = 0;
      end
      while (!dseen) begin @(negedge clk); #3; end
      in_op = 0;
      chk(!busy, "R10", busy, 0);
      if (!stl) chk(bcyc == (glob ? 36 : 8), "R8", bcyc, glob ? 36 : 8);
      chk(wbn == expw, cur_req, wbn, expw);
      @(negedge clk); #3;
      chk(!done && !busy, intr ? "R11" : "R10", {done, busy}, 0);
      stall = 0;
      for (int c = 0; c < 3; c++)
         for (int i = 0; i < 32; i++)
            if (rv[c][i] && (glob || in_pg(la[c][i], pn))) begin rv[c][i] = 0; rd[c][i] = 0; end
      check_all(prq);
   endtask

   initial begin
      void'($urandom(32'h5eed));
      repeat (4) @(negedge clk);
      #3 rst_n = 1;
      @(negedge clk); #3;
      chk(!busy && !done && !wb_valid, "R10", {busy, done, wb_valid}, 0);
      probe_cache = 2'd2; probe_addr = '0; #1;
      chk(!probe_hit, "R13", probe_hit, 0);

      // directed: page 2 lines plus neighbours, write-back mode
      fill(0, 'h080, 1); fill(1, 'h090, 1); fill(1, 'h0A0, 0);
      fill(2, 'h080, 1); fill(2, 'h0B0, 1); fill(2, 'h0C0, 1); fill(2, 'h470, 1);
      check_all("R13");
      run_op(1, 2, 0, 0);
      // directed: invalidate-only drops modified lines of page 3
      fill(1, 'h0C0, 1); fill(2, 'h0D0, 1); fill(2, 'h0F0, 1);
      run_op(2, 3, 0, 0);
      // directed: requests during a running page operation are ignored
      fill(2, 'h100, 1); fill(2, 'h140, 1); fill(1, 'h150, 1);
      run_op(2, 4, 1, 0);
      // directed: simultaneous requests, global wins
      fill(2, 'h200, 1); fill(1, 'h210, 1); fill(0, 'h300, 0);
      run_op(3, 8, 0, 0);
      // directed: global flush, no stalls
      for (int k = 0; k < 12; k++) fill(k % 3, (k * 48) & 'h3F0, k[0]);
      run_op(0, 0, 0, 0);

      // random rounds with writeback stalls
      for (int r = 0; r < 10; r++) begin
         for (int k = 0; k < 24; k++)
            fill(int'($urandom % 3), int'(($urandom % 1024) & 'h3F0), 1'($urandom % 2));
         run_op(int'($urandom % 3), int'($urandom % 16), 0, 1);
      end
      for (int k = 0; k < 24; k++)
         fill(int'($urandom % 3), int'(($urandom % 1024) & 'h3F0), 1'($urandom % 2));
      run_op(1, int'($urandom % 16), 0, 0);

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule